// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

A binary counter of parameterised width (four bits by default) that steps up on a rising edge of one strobe and down on a rising edge of a second strobe. Both strobes arrive asynchronously and are brought onto a single system clock by a multi-flop synchronizer, then edge-detected. A synchronous clear and an active-low parallel preset override counting and take effect on the next system clock edge.

Two active-low terminal outputs let stages be chained without glue logic. The carry output goes low while the count sits at its maximum and the synchronized up strobe is low. The borrow output goes low while the count is zero and the synchronized down strobe is low. Feeding one stage's carry and borrow into the up and down strobes of the next stage builds a wider up/down counter. The strobes are plain control pins with no handshake, so the block has no stream interface and no back-pressure.

Top module: `dual_strobe_counter`

## Requirements
- R1: After reset, the count is 0 and both carry_n and borrow_n are high.
- R2: A rising edge on up_strb while dn_strb is high adds one to the count, and the count wraps from 15 to 0. The new count appears on the third rising clock edge after the strobe rises.
- R3: A rising edge on dn_strb while up_strb is high subtracts one from the count, and the count wraps from 0 to 15.
- R4: Falling strobe edges leave the count unchanged. A rising edge on one strobe while the other strobe is low also leaves the count unchanged, and no error is flagged.
- R5: When load_n is low at a clock edge, the count takes the value of data. Strobe edges seen while load_n is low are discarded, not queued.
- R6: When clr is high at a clock edge, the count becomes 0. This overrides load_n, data and both strobes.
- R7: borrow_n is low exactly when the count is 0 and the synchronized dn_strb is low. It falls two clock edges after dn_strb falls.
- R8: carry_n is low exactly when the count is 15 and the synchronized up_strb is low.
- R9: If both strobes produce synchronized rising edges in the same cycle, the count holds.
- R10: When carry_n and borrow_n of one stage drive up_strb and dn_strb of a second stage, the two stages count as a single 8-bit up/down counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_strb | input | 1 | Count-up strobe, asynchronous, acts on its rising edge |
| dn_strb | input | 1 | Count-down strobe, asynchronous, acts on its rising edge |
| load_n | input | 1 | Active-low preset, synchronous |
| clr | input | 1 | Active-high clear, synchronous, highest priority |
| data | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal carry, for the next stage's up_strb |
| borrow_n | output | 1 | Active-low terminal borrow, for the next stage's dn_strb |

## Verification
The hardest case to reach from the ports is the wrap of the upper stage in a chained pair. The lower stage must first be walked through sixteen complete strobe pulses, and each of its carry edges must cross the second stage's synchronizer before the next pulse arrives. The stimulus uses wide pulses that leave room for both synchronizer delays before the combined value is read. Edges that the counter must discard are created on purpose: a strobe rises while its partner is held low, a strobe rises while the preset is held, and both strobes rise on the same clock. In each case the count is read after the strobe has passed through the synchronizer.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  localparam int unsigned STRB_UP = 0;
  localparam int unsigned STRB_DN = 1;
  localparam int unsigned N_STRB  = 2;
endpackage

// File: rtl/udc_strobe_sync.sv
module udc_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_async,
  output logic strb_lvl,
  output logic strb_rise
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;  // idle strobes are high: no false edge after reset
    else        chain <= {chain[STAGES-1:0], strb_async};
  end

  assign strb_lvl  = chain[STAGES-1];
  assign strb_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/udc_step_arbiter.sv
module udc_step_arbiter
  import udc_pkg::*;
(
  input  logic  up_lvl,
  input  logic  up_rise,
  input  logic  dn_lvl,
  input  logic  dn_rise,
  output step_e step
);
  logic inc_ok, dec_ok;

  always_comb begin
    inc_ok = up_rise & dn_lvl;
    dec_ok = dn_rise & up_lvl;
    step   = STEP_HOLD;
    if (inc_ok && !dec_ok)      step = STEP_INC;
    else if (dec_ok && !inc_ok) step = STEP_DEC;
  end
endmodule

// File: rtl/udc_count_reg.sv
module udc_count_reg
  import udc_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data,
  input  step_e            step,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clr)     count <= '0;
    else if (!load_n) count <= data;
    else begin
      case (step)
        STEP_INC: count <= count + ONE;
        STEP_DEC: count <= count - ONE;
        default:  count <= count;
      endcase
    end
  end
endmodule

// File: rtl/udc_terminal.sv
module udc_terminal #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  always_comb begin
    carry_n  = ~((count == CNT_MAX) & ~up_lvl);
    borrow_n = ~((count == '0)      & ~dn_lvl);
  end
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import udc_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_strb,
  input  logic             dn_strb,
  input  logic             load_n,
  input  logic             clr,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  logic [N_STRB-1:0] strb_in, strb_lvl, strb_rise;
  step_e             step;

  assign strb_in[STRB_UP] = up_strb;
  assign strb_in[STRB_DN] = dn_strb;

  for (genvar g = 0; g < N_STRB; g++) begin : g_sync
    udc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .strb_async(strb_in[g]),
      .strb_lvl  (strb_lvl[g]),
      .strb_rise (strb_rise[g])
    );
  end

  udc_step_arbiter u_arb (
    .up_lvl (strb_lvl[STRB_UP]),
    .up_rise(strb_rise[STRB_UP]),
    .dn_lvl (strb_lvl[STRB_DN]),
    .dn_rise(strb_rise[STRB_DN]),
    .step   (step)
  );

  udc_count_reg #(.WIDTH(WIDTH)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .load_n(load_n),
    .data  (data),
    .step  (step),
    .count (count)
  );

  udc_terminal #(.WIDTH(WIDTH)) u_term (
    .count   (count),
    .up_lvl  (strb_lvl[STRB_UP]),
    .dn_lvl  (strb_lvl[STRB_DN]),
    .carry_n (carry_n),
    .borrow_n(borrow_n)
  );
endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             clr,
  input logic [WIDTH-1:0] data,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n
);
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  p_preset_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !clr) |=> (count == $past(data)));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_n) && !$past(clr) && (count != $past(count)))
      |-> ((count == $past(count) + ONE) || (count == $past(count) - ONE)));

  p_borrow_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (count == '0));

  p_carry_at_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (count == CNT_MAX));
endmodule

bind dual_strobe_counter udc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_n  (load_n),
  .clr     (clr),
  .data    (data),
  .count   (count),
  .carry_n (carry_n),
  .borrow_n(borrow_n)
);

// File: tb/dual_strobe_counter_tb.sv
module dual_strobe_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up_strb = 1'b1, dn_strb = 1'b1, load_n = 1'b1, clr = 1'b0;
  logic [3:0] data = 4'd0;
  logic [3:0] count, hi_count;
  logic       carry_n, borrow_n, hi_carry_n, hi_borrow_n;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  dual_strobe_counter u_dut (
    .clk(clk), .rst_n(rst_n), .up_strb(up_strb), .dn_strb(dn_strb),
    .load_n(load_n), .clr(clr), .data(data),
    .count(count), .carry_n(carry_n), .borrow_n(borrow_n));

  // second stage fed from the first stage's terminal outputs
  dual_strobe_counter u_hi (
    .clk(clk), .rst_n(rst_n), .up_strb(carry_n), .dn_strb(borrow_n),
    .load_n(load_n), .clr(clr), .data(data),
    .count(hi_count), .carry_n(hi_carry_n), .borrow_n(hi_borrow_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up_strb = 1'b0; wait_n(4);
    up_strb = 1'b1; wait_n(6);
  endtask

  task automatic pulse_dn();
    dn_strb = 1'b0; wait_n(4);
    dn_strb = 1'b1; wait_n(6);
  endtask

  task automatic do_clear();
    clr = 1'b1; wait_n(1); clr = 1'b0; wait_n(1);
  endtask

  task automatic do_load(input logic [3:0] v);
    data = v; load_n = 1'b0; wait_n(1); load_n = 1'b1; wait_n(1);
  endtask

  task automatic t_reset();
    check(count == 4'd0, "R1 count", count, 0);
    check(carry_n && borrow_n, "R1 terminals high", {carry_n, borrow_n}, 3);
  endtask

  task automatic t_latency();
    do_load(4'd6);
    up_strb = 1'b0; wait_n(4);
    up_strb = 1'b1;
    wait_n(2);
    check(count == 4'd6, "R2 not yet after two edges", count, 6);
    wait_n(1);
    check(count == 4'd7, "R2 after third edge", count, 7);
    wait_n(4);
  endtask

  task automatic t_sequence();
    do_clear();
    check(count == 4'd0, "R6 clear", count, 0);
    do_load(4'd13);
    check(count == 4'd13, "R5 preset 13", count, 13);
    pulse_up(); check(count == 4'd14, "R2 up to 14", count, 14);
    pulse_up(); check(count == 4'd15, "R2 up to 15", count, 15);
    up_strb = 1'b0; wait_n(3);
    check(!carry_n, "R8 carry low at 15", carry_n, 0);
    check(borrow_n, "R7 borrow idle", borrow_n, 1);
    up_strb = 1'b1; wait_n(6);
    check(count == 4'd0 && carry_n, "R2 wrap to 0", count, 0);
    pulse_up(); pulse_up();
    check(count == 4'd2, "R2 up to 2", count, 2);
    pulse_dn(); check(count == 4'd1, "R3 down to 1", count, 1);
    pulse_dn(); check(count == 4'd0, "R3 down to 0", count, 0);
    dn_strb = 1'b0; wait_n(1);
    check(borrow_n, "R7 borrow after one edge", borrow_n, 1);
    wait_n(1);
    check(!borrow_n, "R7 borrow after two edges", borrow_n, 0);
    wait_n(2);
    dn_strb = 1'b1; wait_n(6);
    check(count == 4'd15 && borrow_n, "R3 wrap to 15", count, 15);
    pulse_dn(); pulse_dn();
    check(count == 4'd13, "R3 down to 13", count, 13);
  endtask

  task automatic t_blocked();
    do_load(4'd5);
    up_strb = 1'b0; wait_n(6);
    check(count == 4'd5, "R4 falling edge ignored", count, 5);
    dn_strb = 1'b0; wait_n(4);
    up_strb = 1'b1; wait_n(6);
    check(count == 4'd5, "R4 up while down low ignored", count, 5);
    dn_strb = 1'b1; wait_n(6);
    check(count == 4'd4, "R3 down rise with up high", count, 4);
  endtask

  task automatic t_load_discard();
    data = 4'd9; load_n = 1'b0; wait_n(1);
    check(count == 4'd9, "R5 load next edge", count, 9);
    up_strb = 1'b0; wait_n(4); up_strb = 1'b1; wait_n(6);
    load_n = 1'b1; wait_n(6);
    check(count == 4'd9, "R5 edge during load discarded", count, 9);
    pulse_up();
    check(count == 4'd10, "R5 counting resumes", count, 10);
  endtask

  task automatic t_clear_priority();
    data = 4'd11; load_n = 1'b0; clr = 1'b1; wait_n(1);
    check(count == 4'd0, "R6 clear beats load", count, 0);
    load_n = 1'b1;
    up_strb = 1'b0; wait_n(4); up_strb = 1'b1; wait_n(6);
    clr = 1'b0; wait_n(2);
    check(count == 4'd0, "R6 edge during clear discarded", count, 0);
  endtask

  task automatic t_simultaneous();
    do_load(4'd8);
    up_strb = 1'b0; dn_strb = 1'b0; wait_n(4);
    up_strb = 1'b1; dn_strb = 1'b1; wait_n(6);
    check(count == 4'd8, "R9 simultaneous rises hold", count, 8);
  endtask

  task automatic t_cascade();
    do_clear();
    for (int i = 0; i < 20; i++) pulse_up();
    wait_n(6);
    check({hi_count, count} == 8'd20, "R10 cascade up to 20", {hi_count, count}, 20);
    for (int i = 0; i < 5; i++) pulse_dn();
    wait_n(6);
    check({hi_count, count} == 8'd15, "R10 cascade down to 15", {hi_count, count}, 15);
    for (int i = 0; i < 16; i++) pulse_dn();
    wait_n(6);
    check({hi_count, count} == 8'd255, "R10 cascade wrap to 255", {hi_count, count}, 255);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_latency();
    t_sequence();
    t_blocked();
    t_load_discard();
    t_clear_priority();
    t_simultaneous();
    t_cascade();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule